// File: doc/BRIEF.md
# Memory Tag Check Unit

This block checks memory accesses against colours. A small tag store gives every 16-byte granule of a modelled memory region a 4-bit colour. An allocator gives a granule range one colour with a fill command. The allocator also places the same colour as a key in the upper bits of the pointer it hands out. On every load or store, the unit reads the key from the pointer and compares it with the stored colour of each granule the access touches. A mismatch is a tag fault.

A per-access mode bit selects how a fault is reported. In blocking mode, the faulting access is refused and reported with its exact pointer. In deferred mode, the access is allowed to go ahead, and a sticky log keeps the first faulting pointer for software to collect later. A global enable bit turns all checking off.

Top module: `mtc_unit`

## Requirements
- R1: After reset, `fill_busy`, `res_valid`, `log_fault` and `log_ovf` are all 0.
- R2: The key is pointer bits [59:56]. The granule index is pointer bits [GI_W+3:4]. An access whose key equals the stored colour gives `res_valid`=1, `res_pass`=1 and `res_fault`=0 in the cycle after `acc_valid`, with `res_ptr` equal to the pointer.
- R3: When checking is enabled and `async_mode`=0, a mismatching access gives `res_pass`=0 and `res_fault`=1 in the next cycle, with `res_ptr` equal to the faulting pointer.
- R4: An access covers the bytes from the pointer to the pointer plus `acc_len` (inclusive). The end granule is computed modulo the region size. Both the start granule and the end granule must match the key, or the access faults.
- R5: When `async_mode`=1, a mismatching access gives `res_pass`=1 and `res_fault`=0. If the log is empty, `log_fault` becomes 1 and `log_ptr` takes the pointer in the next cycle.
- R6: While `log_fault`=1, later deferred faults leave `log_ptr` unchanged and set `log_ovf`. A `log_clr` pulse clears all three log fields. A fault in the same cycle as `log_clr` is logged as the new first fault.
- R7: When `chk_en`=0, every access passes with no fault, and the log is not changed.
- R8: A fill (`set_req`=1 while not busy, `set_cnt`>0) writes `set_color` to `set_cnt` granules, one per cycle. It starts at `set_base` and wraps around the region. `fill_busy` is 1 for exactly `set_cnt` cycles, starting the cycle after the request. A request while busy is ignored, and `set_cnt`=0 does nothing.
- R9: For a fixed stored colour, exactly one of the 16 key values passes.
- R10: After reset, every granule holds colour 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Global check enable |
| async_mode | input | 1 | 0 = blocking fault report, 1 = deferred log |
| set_req | input | 1 | Start a colour fill |
| set_base | input | GI_W | First granule of the fill |
| set_cnt | input | GI_W+1 | Number of granules to fill |
| set_color | input | 4 | Colour to write |
| fill_busy | output | 1 | Fill in progress |
| acc_valid | input | 1 | Access present this cycle |
| acc_ptr | input | 64 | Tagged pointer of the access |
| acc_len | input | 4 | Access size in bytes minus one |
| res_valid | output | 1 | Check result valid |
| res_pass | output | 1 | Access allowed |
| res_fault | output | 1 | Blocking tag fault |
| res_ptr | output | 64 | Pointer of the checked access |
| log_clr | input | 1 | Clear the deferred fault log |
| log_fault | output | 1 | Deferred fault recorded |
| log_ovf | output | 1 | More deferred faults after the first |
| log_ptr | output | 64 | First deferred faulting pointer |

## Verification
An access result and any log update are due one clock after the cycle in which `acc_valid` is high. An access checks the colours as they stood before that clock edge. `fill_busy` rises one clock after an accepted request and then stays high for `set_cnt` cycles, with one granule written at each of those edges. Inputs are driven and outputs sampled on the falling edge. A behavioural model in the bench is updated on each rising edge, so every comparison and directed check reads the values the design registered one cycle after the stimulus.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    localparam int TAG_W      = 4;
    localparam int GRAN_SHIFT = 4;
    localparam int PTR_W      = 64;
    localparam int KEY_LSB    = 56;
    localparam int LEN_W      = 4;
    localparam int LANES      = 2;

    typedef logic [TAG_W-1:0] color_t;
    typedef logic [PTR_W-1:0] ptr_t;
endpackage

// File: rtl/mtc_tag_store.sv
module mtc_tag_store
    import mtc_pkg::*;
#(
    parameter int GI_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_req,
    input  logic [GI_W-1:0]             set_base,
    input  logic [GI_W:0]               set_cnt,
    input  color_t                      set_color,
    output logic                        busy,
    input  logic [LANES-1:0][GI_W-1:0]  rd_idx,
    output color_t [LANES-1:0]          rd_col
);
    localparam int NG = 1 << GI_W;

    typedef struct packed {
        logic                       busy;
        logic [GI_W-1:0]            cur;
        logic [GI_W:0]              rem;
        color_t                     color;
        logic [NG-1:0][TAG_W-1:0]   tags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.tags[st_q.cur] = st_q.color;
            st_d.cur            = st_q.cur + 1'b1;
            st_d.rem            = st_q.rem - 1'b1;
            if (st_q.rem == (GI_W+1)'(1)) begin
                st_d.busy = 1'b0;
            end
        end else if (set_req && (set_cnt != '0)) begin
            st_d.busy  = 1'b1;
            st_d.cur   = set_base;
            st_d.rem   = set_cnt;
            st_d.color = set_color;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

    for (genvar i = 0; i < LANES; i++) begin : g_rd
        assign rd_col[i] = st_q.tags[rd_idx[i]];
    end

    // R8
    fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !busy && (set_cnt != '0)) |=> busy);
    // R8
    fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(set_req));
endmodule

// File: rtl/mtc_key_compare.sv
module mtc_key_compare
    import mtc_pkg::*;
(
    input  color_t              key,
    input  color_t [LANES-1:0]  col,
    output logic                match
);
    logic [LANES-1:0] eq;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign eq[i] = (col[i] == key);
    end

    assign match = &eq;
endmodule

// File: rtl/mtc_fault_log.sv
module mtc_fault_log
    import mtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rec,
    input  ptr_t rec_ptr,
    output logic flag,
    output logic ovf,
    output ptr_t ptr
);
    typedef struct packed {
        logic flag;
        logic ovf;
        ptr_t ptr;
    } log_t;

    log_t lg_d, lg_q;

    always_comb begin
        lg_d = lg_q;
        if (clr) begin
            lg_d = '0;
        end
        if (rec) begin
            if (!lg_d.flag) begin
                lg_d.flag = 1'b1;
                lg_d.ptr  = rec_ptr;
            end else begin
                lg_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lg_q <= '0;
        end else begin
            lg_q <= lg_d;
        end
    end

    assign flag = lg_q.flag;
    assign ovf  = lg_q.ovf;
    assign ptr  = lg_q.ptr;

    // R6
    first_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> (flag && $stable(ptr)));
    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && rec && !clr) |=> ovf);
endmodule

// File: rtl/mtc_unit.sv
module mtc_unit
    import mtc_pkg::*;
#(
    parameter int GI_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              async_mode,
    input  logic              set_req,
    input  logic [GI_W-1:0]   set_base,
    input  logic [GI_W:0]     set_cnt,
    input  logic [TAG_W-1:0]  set_color,
    output logic              fill_busy,
    input  logic              acc_valid,
    input  logic [PTR_W-1:0]  acc_ptr,
    input  logic [LEN_W-1:0]  acc_len,
    output logic              res_valid,
    output logic              res_pass,
    output logic              res_fault,
    output logic [PTR_W-1:0]  res_ptr,
    input  logic              log_clr,
    output logic              log_fault,
    output logic              log_ovf,
    output logic [PTR_W-1:0]  log_ptr
);
    localparam int OFF_W = GI_W + GRAN_SHIFT;

    typedef struct packed {
        logic valid;
        logic pass;
        logic fault;
        ptr_t ptr;
    } res_t;

    res_t res_d, res_q;

    logic [LANES-1:0][GI_W-1:0] rd_idx;
    color_t [LANES-1:0]         rd_col;
    color_t                     key;
    logic [OFF_W-1:0]           off0;
    logic                       match;
    logic                       bad;
    logic                       log_rec;

    mtc_tag_store #(.GI_W(GI_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (set_req),
        .set_base  (set_base),
        .set_cnt   (set_cnt),
        .set_color (set_color),
        .busy      (fill_busy),
        .rd_idx    (rd_idx),
        .rd_col    (rd_col)
    );

    mtc_key_compare u_cmp (
        .key   (key),
        .col   (rd_col),
        .match (match)
    );

    mtc_fault_log u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (log_clr),
        .rec     (log_rec),
        .rec_ptr (acc_ptr),
        .flag    (log_fault),
        .ovf     (log_ovf),
        .ptr     (log_ptr)
    );

    always_comb begin
        key       = acc_ptr[KEY_LSB +: TAG_W];
        off0      = acc_ptr[OFF_W-1:0];
        rd_idx[0] = off0[OFF_W-1:GRAN_SHIFT];
        rd_idx[1] = GI_W'((off0 + OFF_W'(acc_len)) >> GRAN_SHIFT);
        bad       = chk_en && !match;
        log_rec   = acc_valid && bad && async_mode;

        res_d       = res_q;
        res_d.valid = acc_valid;
        if (acc_valid) begin
            res_d.pass  = !bad || async_mode;
            res_d.fault = bad && !async_mode;
            res_d.ptr   = acc_ptr;
        end else begin
            res_d.pass  = 1'b0;
            res_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_pass  = res_q.pass;
    assign res_fault = res_q.fault;
    assign res_ptr   = res_q.ptr;

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (res_valid && (res_ptr == $past(acc_ptr))));
    // R3
    block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_valid && !res_pass));
    // R5
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && async_mode) |=> (res_pass && !res_fault));
    // R7
    off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !chk_en) |=> (res_pass && !res_fault));
endmodule

// File: tb/mtc_unit_bench.sv
module mtc_unit_bench;
    localparam int GI_W = 6;
    localparam int NG   = 1 << GI_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b1, async_mode = 1'b0;
    logic        set_req = 1'b0;
    logic [GI_W-1:0] set_base = '0;
    logic [GI_W:0]   set_cnt = '0;
    logic [3:0]  set_color = '0;
    logic        fill_busy;
    logic        acc_valid = 1'b0;
    logic [63:0] acc_ptr = '0;
    logic [3:0]  acc_len = '0;
    logic        res_valid, res_pass, res_fault;
    logic [63:0] res_ptr;
    logic        log_clr = 1'b0;
    logic        log_fault, log_ovf;
    logic [63:0] log_ptr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mtc_unit #(.GI_W(GI_W)) u_mtc_unit (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .async_mode(async_mode),
        .set_req(set_req), .set_base(set_base), .set_cnt(set_cnt),
        .set_color(set_color), .fill_busy(fill_busy),
        .acc_valid(acc_valid), .acc_ptr(acc_ptr), .acc_len(acc_len),
        .res_valid(res_valid), .res_pass(res_pass), .res_fault(res_fault),
        .res_ptr(res_ptr), .log_clr(log_clr), .log_fault(log_fault),
        .log_ovf(log_ovf), .log_ptr(log_ptr)
    );

    // behavioural reference model
    int          m_tag[NG];
    bit          m_busy;
    int          m_cur, m_rem, m_col;
    bit          m_rv, m_rp, m_rf;
    logic [63:0] m_rptr;
    bit          m_lf, m_lo;
    logic [63:0] m_lptr;
    int          m_a, m_g0, m_g1, m_k;
    bit          m_bad;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_tag[i]) m_tag[i] = 0;
            m_busy = 0; m_cur = 0; m_rem = 0; m_col = 0;
            m_rv = 0; m_rp = 0; m_rf = 0; m_rptr = '0;
            m_lf = 0; m_lo = 0; m_lptr = '0;
        end else begin
            if (log_clr) begin
                m_lf = 0; m_lo = 0; m_lptr = '0;
            end
            if (acc_valid) begin
                m_a   = int'(acc_ptr[9:0]);
                m_g0  = m_a / 16;
                m_g1  = ((m_a + int'(acc_len)) % (NG * 16)) / 16;
                m_k   = int'(acc_ptr[59:56]);
                m_bad = chk_en && ((m_tag[m_g0] != m_k) || (m_tag[m_g1] != m_k));
                m_rv = 1; m_rp = !m_bad || async_mode; m_rf = m_bad && !async_mode;
                m_rptr = acc_ptr;
                if (m_bad && async_mode) begin
                    if (!m_lf) begin m_lf = 1; m_lptr = acc_ptr; end
                    else m_lo = 1;
                end
            end else begin
                m_rv = 0; m_rp = 0; m_rf = 0;
            end
            if (m_busy) begin
                m_tag[m_cur] = m_col;
                m_cur = (m_cur + 1) % NG;
                m_rem = m_rem - 1;
                if (m_rem == 0) m_busy = 0;
            end else if (set_req && set_cnt != 0) begin
                m_busy = 1; m_cur = int'(set_base); m_rem = int'(set_cnt);
                m_col = int'(set_color);
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    bit started = 0;
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk("R2", "model res_valid", 64'(res_valid), 64'(m_rv));
            if (m_rv) begin
                chk("R3", "model res_pass", 64'(res_pass), 64'(m_rp));
                chk("R3", "model res_fault", 64'(res_fault), 64'(m_rf));
                chk("R2", "model res_ptr", res_ptr, m_rptr);
            end
            chk("R8", "model fill_busy", 64'(fill_busy), 64'(m_busy));
            chk("R5", "model log_fault", 64'(log_fault), 64'(m_lf));
            chk("R6", "model log_ovf", 64'(log_ovf), 64'(m_lo));
            chk("R6", "model log_ptr", log_ptr, m_lptr);
        end
    end

    function automatic logic [63:0] mk(input int key, input int gran, input int off);
        logic [63:0] p;
        p        = 64'h0000_2345_6789_AC00;
        p[59:56] = 4'(key);
        p[9:0]   = 10'(gran * 16 + off);
        return p;
    endfunction

    task automatic acc(input logic [63:0] p, input int len, input bit asy, input bit en);
        acc_valid = 1; acc_ptr = p; acc_len = 4'(len); async_mode = asy; chk_en = en;
        @(negedge clk);
        acc_valid = 0; async_mode = 0; chk_en = 1;
    endtask

    task automatic expect_res(input string tag, input bit pass, input bit fault);
        chk(tag, "res_valid", 64'(res_valid), 64'd1);
        chk(tag, "res_pass", 64'(res_pass), 64'(pass));
        chk(tag, "res_fault", 64'(res_fault), 64'(fault));
    endtask

    task automatic fill(input int base, input int cnt, input int col, output int n);
        set_req = 1; set_base = GI_W'(base); set_cnt = (GI_W+1)'(cnt); set_color = 4'(col);
        @(negedge clk);
        set_req = 0;
        n = 0;
        while (fill_busy && n < 200) begin
            n++;
            if (n == 1) begin
                set_req = 1; set_base = GI_W'(base); set_cnt = 1; set_color = 4'hC;
            end else set_req = 0;
            @(negedge clk);
        end
        set_req = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int passes;
        logic [63:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1;
        started = 1;
        @(negedge clk);
        // R1
        chk("R1", "fill_busy", 64'(fill_busy), 0);
        chk("R1", "res_valid", 64'(res_valid), 0);
        chk("R1", "log_fault", 64'(log_fault), 0);
        chk("R1", "log_ovf", 64'(log_ovf), 0);

        // R10: all colours 0 after reset
        acc(mk(0, 5, 0), 0, 0, 1);  expect_res("R10", 1, 0);
        acc(mk(0, 63, 3), 0, 0, 1); expect_res("R10", 1, 0);
        p = mk(3, 5, 0);
        acc(p, 0, 0, 1);            expect_res("R3", 0, 1);
        chk("R3", "res_ptr", res_ptr, p);

        // R8: fill 2..5 with 7, intrusive request while busy is ignored
        fill(2, 4, 7, n);
        chk("R8", "busy cycles", 64'(n), 4);
        acc(mk(7, 2, 0), 0, 0, 1);  expect_res("R8", 1, 0);
        acc(mk(7, 3, 4), 0, 0, 1);  expect_res("R2", 1, 0);
        acc(mk(6, 3, 4), 0, 0, 1);  expect_res("R3", 0, 1);

        // R4: spanning accesses
        acc(mk(7, 5, 12), 7, 0, 1); expect_res("R4", 0, 1);
        acc(mk(7, 2, 8), 15, 0, 1); expect_res("R4", 1, 0);
        acc(mk(7, 5, 0), 15, 0, 1); expect_res("R4", 1, 0);

        // R8: wrapping fill 62,63,0,1 with 9
        fill(62, 4, 9, n);
        chk("R8", "wrap busy cycles", 64'(n), 4);
        acc(mk(9, 1, 0), 0, 0, 1);  expect_res("R8", 1, 0);
        acc(mk(9, 2, 0), 0, 0, 1);  expect_res("R8", 0, 1);
        acc(mk(9, 63, 10), 8, 0, 1); expect_res("R4", 1, 0);

        // R8: zero count does nothing
        fill(10, 0, 5, n);
        chk("R8", "zero count busy", 64'(n), 0);
        acc(mk(5, 10, 0), 0, 0, 1); expect_res("R8", 0, 1);

        // R9: only the equal key passes
        passes = 0;
        for (int k = 0; k < 16; k++) begin
            acc(mk(k, 3, 0), 0, 0, 1);
            if (res_pass) passes++;
        end
        chk("R9", "passing keys", 64'(passes), 1);

        // R5 / R6: deferred mode
        p = mk(1, 3, 0);
        acc(p, 0, 1, 1);            expect_res("R5", 1, 0);
        chk("R5", "log_fault", 64'(log_fault), 1);
        chk("R5", "log_ptr", log_ptr, p);
        acc(mk(2, 4, 0), 0, 1, 1);  expect_res("R5", 1, 0);
        chk("R6", "log_ptr kept", log_ptr, p);
        chk("R6", "log_ovf", 64'(log_ovf), 1);
        log_clr = 1;
        @(negedge clk);
        log_clr = 0;
        chk("R6", "clr fault", 64'(log_fault), 0);
        chk("R6", "clr ovf", 64'(log_ovf), 0);
        // clear together with a fault logs the new one
        p = mk(4, 4, 0);
        log_clr = 1;
        acc(p, 0, 1, 1);
        log_clr = 0;
        chk("R6", "clr+fault flag", 64'(log_fault), 1);
        chk("R6", "clr+fault ptr", log_ptr, p);
        chk("R6", "clr+fault ovf", 64'(log_ovf), 0);
        log_clr = 1;
        @(negedge clk);
        log_clr = 0;

        // R7: disabled checking
        acc(mk(1, 3, 0), 0, 0, 0);  expect_res("R7", 1, 0);
        acc(mk(1, 3, 0), 0, 1, 0);  expect_res("R7", 1, 0);
        chk("R7", "log untouched", 64'(log_fault), 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule